// File: doc/BRIEF.md
# GPIO Edge-Detect Interrupt Unit

This block watches the already-synchronized levels of 128 general-purpose pins, grouped as four banks of 32. It looks for rising and falling transitions on pins that are configured as inputs. When a transition happens and its type is enabled for that pin, the block records it in a sticky status bit. Software clears a status bit by writing a 1 to it.

Three level-sensitive, active-high interrupt lines are derived from the status bits:
- Pin 0 has its own interrupt line.
- Pin 1 has its own interrupt line.
- Every other pin feeds one shared line.

A separate wake request pulses for one cycle when the core is halted and an input pin that belongs to a fixed wake map changes level.

The pin direction vector comes from the neighbouring output/direction controller. This block only reads it.

Software reaches the per-bank rising-enable, falling-enable and status registers through a simple 32-bit register port. A write takes effect on the clock edge that samples it. Read data appears on the cycle after the read strobe.

Top module: `gpio_edge_irq`

## Requirements
- R1: A status bit becomes 1 on the clock edge after its pin goes from 0 to 1, if its rising-enable bit is 1 and its direction bit is 0 (input).
- R2: A status bit becomes 1 on the clock edge after its pin goes from 1 to 0, if its falling-enable bit is 1 and its direction bit is 0. A rising transition on a pin enabled only for falling transitions sets nothing.
- R3: No status bit is set for a pin whose direction bit is 1 (output), or for a transition type whose enable bit is 0.
- R4: Status bits are sticky. A write to a status register clears each bit written as 1 and leaves each bit written as 0 unchanged. Nothing else clears a status bit except reset.
- R5: When a set condition and a write-1-to-clear hit the same status bit in the same cycle, the bit ends up 1.
- R6: `irq_pin0` and `irq_pin1` equal bank 0 status bits 0 and 1, delayed by one register stage.
- R7: `irq_shared` is 1, one cycle after the fact, whenever any status bit other than bank 0 bits 0 and 1 is set.
- R8: `wake_req` is high for exactly one cycle, on the cycle after an input pin changes level, when `core_halted` is 1 and the pin's bit is set in the wake map. Banks 0..3 use the maps 0x8003FE1B, 0x002001FC, 0xEC080000 and 0x0012007F. Otherwise `wake_req` stays 0.
- R9: The byte address is {kind[1:0], bank[1:0], 2'b00}. Kind 0 is rising-enable, kind 1 is falling-enable, kind 2 is status, and kind 3 is unmapped. Enables are plain read/write. `rdata` holds the addressed value on the cycle after `rd_en`. Unmapped reads return 0, and unmapped writes change nothing.
- R10: Reset clears all enables, status bits, interrupts and the wake request. The first cycle after reset is never treated as a transition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| pin_level | input | 128 | Synchronized pin levels, bit 32*bank+index |
| pin_dir | input | 128 | Pin direction, 1 = output |
| core_halted | input | 1 | Core is in a halted state |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 6 | Register byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after rd_en |
| irq_pin0 | output | 1 | Interrupt for pin 0 status |
| irq_pin1 | output | 1 | Interrupt for pin 1 status |
| irq_shared | output | 1 | Interrupt for all other status bits |
| wake_req | output | 1 | One-cycle wake pulse |

## Verification
The assertions assume that `pin_level` is already synchronous to `clk`, that `pin_dir` is stable in the cycle an edge is judged, and that status is only cleared through a register write. Under those assumptions, any status bit that falls without a write, or any newly set bit on an output pin, is a design fault.

The stimulus respects these assumptions:
- It changes pins and direction only between clock edges.
- It never toggles a pin and its direction bit in the same cycle.
- It brings status back to zero only through the write-1-to-clear path.
- It collides a new transition with a clear exactly once, on purpose, to exercise R5.

// File: rtl/gpei_pkg.sv
package gpei_pkg;
  typedef enum logic [1:0] {
    KIND_RISE = 2'd0,
    KIND_FALL = 2'd1,
    KIND_STAT = 2'd2,
    KIND_NONE = 2'd3
  } reg_kind_e;
endpackage

// File: rtl/gpei_bank.sv
module gpei_bank #(
  parameter int              W         = 32,
  parameter logic [W-1:0]    WAKE_MASK = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         armed,
  input  logic [W-1:0] level,
  input  logic [W-1:0] dir,
  input  logic         halted,
  input  logic         rise_we,
  input  logic         fall_we,
  input  logic         stat_we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rise_en,
  output logic [W-1:0] fall_en,
  output logic [W-1:0] status,
  output logic         wake_hit
);
  logic [W-1:0] prev;
  logic [W-1:0] change, set_v, clr_v;

  always_comb begin
    change   = armed ? (level ^ prev) : '0;
    set_v    = ((change & level & rise_en) | (change & ~level & fall_en)) & ~dir;
    clr_v    = stat_we ? wdata : '0;
    wake_hit = halted && ((change & ~dir & WAKE_MASK) != '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev    <= '0;
      rise_en <= '0;
      fall_en <= '0;
      status  <= '0;
    end else begin
      prev <= level;
      if (rise_we) rise_en <= wdata;
      if (fall_we) fall_en <= wdata;
      status <= (status & ~clr_v) | set_v;
    end
  end
endmodule

// File: rtl/gpei_irq_merge.sv
module gpei_irq_merge #(
  parameter int NUM_BANKS = 4,
  parameter int BANK_W    = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_BANKS*BANK_W-1:0] status_flat,
  input  logic [NUM_BANKS-1:0]        wake_hits,
  output logic                        irq_pin0,
  output logic                        irq_pin1,
  output logic                        irq_shared,
  output logic                        wake_req
);
  localparam int TOTAL = NUM_BANKS * BANK_W;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_pin0   <= 1'b0;
      irq_pin1   <= 1'b0;
      irq_shared <= 1'b0;
      wake_req   <= 1'b0;
    end else begin
      irq_pin0   <= status_flat[0];
      irq_pin1   <= status_flat[1];
      irq_shared <= |status_flat[TOTAL-1:2];
      wake_req   <= |wake_hits;
    end
  end
endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq
  import gpei_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int BANK_W    = 32,
  parameter int ADDR_W    = 4 + ((NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1),
  parameter logic [NUM_BANKS*BANK_W-1:0] WAKE_MAP =
    {32'h0012_007F, 32'hEC08_0000, 32'h0020_01FC, 32'h8003_FE1B}
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_BANKS*BANK_W-1:0] pin_level,
  input  logic [NUM_BANKS*BANK_W-1:0] pin_dir,
  input  logic                        core_halted,
  input  logic                        wr_en,
  input  logic                        rd_en,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [BANK_W-1:0]           wdata,
  output logic [BANK_W-1:0]           rdata,
  output logic                        irq_pin0,
  output logic                        irq_pin1,
  output logic                        irq_shared,
  output logic                        wake_req
);
  localparam int BANK_BITS = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;
  localparam int TOTAL     = NUM_BANKS * BANK_W;

  reg_kind_e            kind;
  logic [BANK_BITS-1:0] bank_sel;
  logic                 armed;
  logic [BANK_W-1:0]    rise_q [NUM_BANKS];
  logic [BANK_W-1:0]    fall_q [NUM_BANKS];
  logic [BANK_W-1:0]    stat_q [NUM_BANKS];
  logic [NUM_BANKS-1:0] wake_hits;
  logic [TOTAL-1:0]     status_flat;
  logic [BANK_W-1:0]    rd_val;
  logic                 unused_addr_lsb;

  assign kind            = reg_kind_e'(addr[2+BANK_BITS +: 2]);
  assign bank_sel        = addr[2 +: BANK_BITS];
  assign unused_addr_lsb = &{1'b0, addr[1:0]};

  // First cycle after reset has no trusted history; suppress edges then.
  always_ff @(posedge clk) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic sel;
    assign sel = (bank_sel == BANK_BITS'(b));

    gpei_bank #(
      .W        (BANK_W),
      .WAKE_MASK(WAKE_MAP[b*BANK_W +: BANK_W])
    ) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .armed   (armed),
      .level   (pin_level[b*BANK_W +: BANK_W]),
      .dir     (pin_dir[b*BANK_W +: BANK_W]),
      .halted  (core_halted),
      .rise_we (wr_en && sel && (kind == KIND_RISE)),
      .fall_we (wr_en && sel && (kind == KIND_FALL)),
      .stat_we (wr_en && sel && (kind == KIND_STAT)),
      .wdata   (wdata),
      .rise_en (rise_q[b]),
      .fall_en (fall_q[b]),
      .status  (stat_q[b]),
      .wake_hit(wake_hits[b])
    );

    assign status_flat[b*BANK_W +: BANK_W] = stat_q[b];
  end

  always_comb begin
    rd_val = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (bank_sel == BANK_BITS'(b)) begin
        case (kind)
          KIND_RISE: rd_val = rise_q[b];
          KIND_FALL: rd_val = fall_q[b];
          KIND_STAT: rd_val = stat_q[b];
          default:   rd_val = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= rd_val;
  end

  gpei_irq_merge #(
    .NUM_BANKS(NUM_BANKS),
    .BANK_W   (BANK_W)
  ) u_merge (
    .clk        (clk),
    .rst_n      (rst_n),
    .status_flat(status_flat),
    .wake_hits  (wake_hits),
    .irq_pin0   (irq_pin0),
    .irq_pin1   (irq_pin1),
    .irq_shared (irq_shared),
    .wake_req   (wake_req)
  );
endmodule

// File: rtl/gpio_edge_irq_chk.sv
module gpio_edge_irq_chk #(
  parameter int NUM_BANKS = 4,
  parameter int BANK_W    = 32,
  parameter int ADDR_W    = 6
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        wr_en,
  input logic [ADDR_W-1:0]           addr,
  input logic [NUM_BANKS*BANK_W-1:0] pin_dir,
  input logic                        core_halted,
  input logic [NUM_BANKS*BANK_W-1:0] status_flat,
  input logic                        irq_pin0,
  input logic                        irq_pin1,
  input logic                        irq_shared,
  input logic                        wake_req
);
  localparam int TOTAL = NUM_BANKS * BANK_W;

  logic stat_write;
  assign stat_write = wr_en && (addr[ADDR_W-1 -: 2] == 2'd2);

  // R4: without a status write no status bit falls
  a_r4_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_write |=> ((status_flat & $past(status_flat)) == $past(status_flat)));

  // R3: newly set bits belong to input pins only
  a_r3_input_only: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_flat & ~$past(status_flat) & $past(pin_dir)) == '0));

  // R6: dedicated lines trail their status bits by one stage
  a_r6_irq0_track: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_pin0 == $past(status_flat[0])));

  a_r6_irq1_track: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_pin1 == $past(status_flat[1])));

  // R7: shared line reflects all remaining status bits
  a_r7_shared_track: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_shared == $past(|status_flat[TOTAL-1:2])));

  // R8: wake only follows a halted cycle
  a_r8_wake_halted: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |-> $past(core_halted));
endmodule

bind gpio_edge_irq gpio_edge_irq_chk #(
  .NUM_BANKS(NUM_BANKS),
  .BANK_W   (BANK_W),
  .ADDR_W   (ADDR_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_en      (wr_en),
  .addr       (addr),
  .pin_dir    (pin_dir),
  .core_halted(core_halted),
  .status_flat(status_flat),
  .irq_pin0   (irq_pin0),
  .irq_pin1   (irq_pin1),
  .irq_shared (irq_shared),
  .wake_req   (wake_req)
);

// File: tb/gpio_edge_irq_test.sv
module gpio_edge_irq_test;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [127:0] pin_level = '0;
  logic [127:0] pin_dir = '0;
  logic         core_halted = 1'b0;
  logic         wr_en = 1'b0;
  logic         rd_en = 1'b0;
  logic [5:0]   addr = '0;
  logic [31:0]  wdata = '0;
  logic [31:0]  rdata;
  logic         irq_pin0, irq_pin1, irq_shared, wake_req;

  int vectors = 0;
  int fails = 0;
  bit summary_done = 1'b0;
  logic rd_q = 1'b0;
  logic [31:0] exp_q[$];
  string tag_q[$];

  always #10 clk = ~clk;

  gpio_edge_irq uut (
    .clk(clk), .rst_n(rst_n), .pin_level(pin_level), .pin_dir(pin_dir),
    .core_halted(core_halted), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq_pin0(irq_pin0), .irq_pin1(irq_pin1),
    .irq_shared(irq_shared), .wake_req(wake_req)
  );

  // R9 address layout: {kind, bank, 2'b00}
  function automatic logic [5:0] ra(int kind, int bank);
    return 6'(kind * 16 + bank * 4);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(logic [5:0] a, logic [31:0] exp, string tag);
    @(negedge clk); rd_en = 1'b1; addr = a;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic setpin(int i, logic v);
    @(negedge clk); pin_level[i] = v;
  endtask

  // scoreboard monitor for read data
  always @(posedge clk) rd_q <= rd_en;
  always @(negedge clk) begin
    if (rd_q) begin
      if (exp_q.size() == 0) begin
        vectors++; fails++;
        $display("FAIL R9 unexpected read actual=%h expected=none", rdata);
      end else begin
        chk(tag_q.pop_front(), rdata, exp_q.pop_front());
      end
    end
  end

  task automatic finish_run();
    if (!summary_done) begin
      summary_done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  initial begin
    #(20 * 50000);
    vectors++; fails++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(2);
    // R10 reset state
    chk("R10 irq0", {31'b0, irq_pin0}, 0);
    chk("R10 irq1", {31'b0, irq_pin1}, 0);
    chk("R10 shared", {31'b0, irq_shared}, 0);
    chk("R10 wake", {31'b0, wake_req}, 0);
    for (int b = 0; b < 4; b++) rd(ra(2, b), 0, "R10 status");
    rd(ra(0, 0), 0, "R10 rise enable");

    // R9 register access
    wr(ra(0, 0), 32'h3);
    wr(ra(0, 1), 32'hFFFF_FFFF);
    wr(ra(1, 2), 32'h20);
    rd(ra(0, 0), 32'h3, "R9 rise b0");
    rd(ra(0, 1), 32'hFFFF_FFFF, "R9 rise b1");
    rd(ra(1, 2), 32'h20, "R9 fall b2");
    wr(ra(3, 0), 32'hFFFF_FFFF);
    rd(ra(3, 0), 0, "R9 unmapped read");
    rd(ra(0, 0), 32'h3, "R9 unmapped write ignored");

    // R1 / R6 rising on pin 0
    setpin(0, 1'b1); tick(2);
    chk("R6 irq0 set", {31'b0, irq_pin0}, 1);
    chk("R6 irq1 clear", {31'b0, irq_pin1}, 0);
    chk("R7 shared clear", {31'b0, irq_shared}, 0);
    rd(ra(2, 0), 32'h1, "R1 status b0");

    // R3 output pin and disabled pin
    @(negedge clk); pin_dir[1] = 1'b1;
    setpin(1, 1'b1);
    setpin(2, 1'b1); tick(2);
    rd(ra(2, 0), 32'h1, "R3 no set on output/disabled");
    chk("R3 irq1 quiet", {31'b0, irq_pin1}, 0);

    // R2 / R7 falling only on pin 69
    setpin(69, 1'b1); tick(2);
    rd(ra(2, 2), 0, "R2 rise ignored with fall enable");
    chk("R7 shared still clear", {31'b0, irq_shared}, 0);
    setpin(69, 1'b0); tick(2);
    rd(ra(2, 2), 32'h20, "R2 fall sets");
    chk("R7 shared set", {31'b0, irq_shared}, 1);
    setpin(40, 1'b1); tick(2);
    rd(ra(2, 1), 32'h100, "R1 status b1");

    // R4 write-1-to-clear
    wr(ra(2, 2), 32'h0);
    rd(ra(2, 2), 32'h20, "R4 write 0 keeps");
    wr(ra(2, 2), 32'h20);
    rd(ra(2, 2), 0, "R4 write 1 clears");
    wr(ra(2, 1), 32'h100);
    tick(1);
    chk("R7 shared after clear", {31'b0, irq_shared}, 0);

    // R5 set wins over clear
    setpin(0, 1'b0); tick(2);
    @(negedge clk);
    pin_level[0] = 1'b1;
    wr_en = 1'b1; addr = ra(2, 0); wdata = 32'h1;
    @(negedge clk); wr_en = 1'b0;
    rd(ra(2, 0), 32'h1, "R5 set wins");
    chk("R5 irq0 held", {31'b0, irq_pin0}, 1);
    wr(ra(2, 0), 32'h1); tick(1);
    chk("R4 irq0 cleared", {31'b0, irq_pin0}, 0);

    // R8 wake requests
    @(negedge clk); core_halted = 1'b1;
    setpin(0, 1'b0); tick(1);
    chk("R8 wake pulse", {31'b0, wake_req}, 1);
    tick(1);
    chk("R8 wake one cycle", {31'b0, wake_req}, 0);
    setpin(2, 1'b0); tick(1);
    chk("R8 pin outside map", {31'b0, wake_req}, 0);
    setpin(1, 1'b0); tick(1);
    chk("R8 output pin", {31'b0, wake_req}, 0);
    @(negedge clk); core_halted = 1'b0;
    setpin(0, 1'b1); tick(1);
    chk("R8 not halted", {31'b0, wake_req}, 0);
    @(negedge clk); core_halted = 1'b1;
    setpin(96, 1'b1); tick(1);
    chk("R8 bank3 wake", {31'b0, wake_req}, 1);

    tick(3);
    finish_run();
  end
endmodule